// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port driven from a simple synchronous register bus. The data register appears at 256 word addresses. Byte-address bits [9:2] of each access act as a per-bit mask. A write changes only the pins selected by the address, so independent drivers can each own a subset of the pins without a read-modify-write sequence. A read returns only the selected pins and reads every other bit as zero.

A separate direction register at byte offset 0x400 sets each pin to input (0) or output (1). Output pins show the stored data bit and have their output enable asserted. Input pins pass through a two-flop synchronizer, and reads return the sampled level. Reads are combinational from registered state. Writes take effect at the clock edge.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to the data window (byte address 0x000 to 0x3FC, mask = address bits [9:2], mask bit i governs data bit i) updates data bit i only when mask bit i is 1. All other bits keep their value.
- R2: A data write has no effect on a bit whose direction bit is 0 (input). The stored value stays unchanged and shows once the pin becomes an output.
- R3: A read of the data window returns 0 in every bit position whose mask bit is 0.
- R4: In a data read, an output pin returns its stored bit. An input pin returns the pin level through a two-stage synchronizer: a change shows after the second rising edge, and not after the first.
- R5: Read data bits [31:8] are always 0, and write data bits [31:8] are ignored.
- R6: The direction register sits at byte offset 0x400 and is not address-masked. Bit i = 1 makes pin i an output. A write stores all 8 bits and a read returns all 8 bits.
- R7: pin_oe equals the direction register and pin_out equals the stored data register.
- R8: Synchronous active-high reset clears the data register, the direction register and the synchronizer. After reset all pins are inputs with pin_oe = 0.
- R9: Word addresses above 0x400 (0x404 to 0xFFC) read as 0. Writes to them change neither register.
- R10: Read data reflects the address in the same cycle. A write shows in read data from the cycle after its clock edge.
- R11: A data write with an all-zero mask (byte address 0x000) changes nothing. A data read with an all-zero mask returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench applies mask patterns that select some of the bits a write sets to 1 and some it sets to 0. A design that ignored the mask would clobber another driver's pins, and one that inverted it would update exactly the wrong bits. It writes to input-configured pins and then turns them into outputs, which exposes a design that stores into input bits even though the pin level hides the store at first. It times input changes against the first and second clock edges to catch a missing or extra synchronizer stage. It also probes the all-zero mask and the address hole above the direction register, where a loose decoder would alias onto one of the registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W   = 8;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 12;
  localparam int MASK_LSB = 2;
  localparam int WIN_MSB  = MASK_LSB + DATA_W;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pkg::*;
#(
  parameter int WIDTH    = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int LSB      = MASK_LSB
) (
  input  logic [AW-1:0]    addr,
  output acc_kind_t        kind,
  output logic [WIDTH-1:0] mask
);
  localparam int TOP = LSB + WIDTH;
  localparam logic [AW-LSB-1:0] DIR_WORD = (AW-LSB)'(1) << WIDTH;

  logic unused_addr_lsbs;
  assign unused_addr_lsbs = ^addr[LSB-1:0];

  assign mask = addr[LSB +: WIDTH];

  always_comb begin
    if (addr[AW-1:TOP] == '0)
      kind = ACC_DATA;
    else if (addr[AW-1:LSB] == DIR_WORD)
      kind = ACC_DIR;
    else
      kind = ACC_NONE;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_wr,
  input  logic             dir_wr,
  input  logic [WIDTH-1:0] wmask,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  logic [WIDTH-1:0] upd;

  assign upd = wmask & dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_wr) data_q <= (data_q & ~upd) | (wval & upd);
      if (dir_wr)  dir_q  <= wval;
    end
  end

  // R1: unmasked bits never move on a data write
  p_masked_hold_r1: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> ((data_q ^ $past(data_q)) & ~$past(wmask)) == '0);

  // R2: input-configured bits never move on a data write
  p_input_hold_r2: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> ((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0);

  // R6: direction only changes through its own write
  p_dir_only_r6: assert property (@(posedge clk) disable iff (rst)
    !dir_wr |=> $stable(dir_q));

  // R8: reset clears both registers
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (data_q == '0 && dir_q == '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  acc_kind_t         kind;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] pin_sync;
  logic [DATA_W-1:0] level;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:DATA_W];

  gpio_bus_decode #(.WIDTH(DATA_W), .AW(ADDR_W), .LSB(MASK_LSB)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .mask (mask)
  );

  gpio_in_sync #(.WIDTH(DATA_W), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_port_regs #(.WIDTH(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .data_wr (bus_wr && kind == ACC_DATA),
    .dir_wr  (bus_wr && kind == ACC_DIR),
    .wmask   (mask),
    .wval    (bus_wdata[DATA_W-1:0]),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  assign level = (data_q & dir_q) | (pin_sync & ~dir_q);

  always_comb begin
    bus_rdata = '0;
    case (kind)
      ACC_DATA: bus_rdata[DATA_W-1:0] = level & mask;
      ACC_DIR:  bus_rdata[DATA_W-1:0] = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  // R3: masked positions read zero
  p_rd_masked_r3: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_DATA |-> (bus_rdata[DATA_W-1:0] & ~mask) == '0);

  // R5: reserved upper bits read zero
  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:DATA_W] == '0);

  // R9: the hole reads zero
  p_hole_r9: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_NONE |-> bus_rdata == '0);
endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic        clk = 0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] dat(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h400, d);   chk("R8 dir", d, 0);
    chk("R8 oe", {24'h0, pin_oe}, 0);
    chk("R8 out", {24'h0, pin_out}, 0);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    wr(12'h400, 32'hFFFF_FF5A);
    rd(12'h400, d);   chk("R6 dir readback", d, 32'h5A);
    chk("R7 oe", {24'h0, pin_oe}, 32'h5A);
    chk("R5 dir upper", d[31:8], 0);
    wr(12'h400, 32'hFF);
    chk("R7 oe all", {24'h0, pin_oe}, 32'hFF);
  endtask

  task automatic t_mask_write();
    logic [31:0] d;
    wr(dat(8'hFF), 32'hFFFF_FF00);
    rd(dat(8'hFF), d); chk("R5 upper ignored", d, 0);
    wr(dat(8'h0F), 32'hFFFF_FF3C);
    rd(dat(8'hFF), d); chk("R1 low nibble", d, 32'h0C);
    wr(dat(8'hA0), 32'h0000_00FF);
    rd(dat(8'hFF), d); chk("R1 bits 7,5", d, 32'hAC);
    chk("R7 pin_out", {24'h0, pin_out}, 32'hAC);
    rd(dat(8'h3C), d); chk("R3 masked read", d, 32'h2C);
    rd(dat(8'h00), d); chk("R11 zero mask read", d, 0);
    wr(dat(8'h00), 32'hFF);
    rd(dat(8'hFF), d); chk("R11 zero mask write", d, 32'hAC);
    wr(12'h002 | dat(8'h01), 32'h01);
    rd(dat(8'hFF), d); chk("R1 addr lsbs ignored", d, 32'hAD);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    @(negedge clk);
    bus_addr = dat(8'hFF); bus_wdata = 32'h00; bus_wr = 1;
    #0.5 chk("R10 same-cycle old", bus_rdata, 32'hAD);
    @(negedge clk);
    bus_wr = 0;
    #0.5 chk("R10 next-cycle new", bus_rdata, 0);
    rd(dat(8'h0F), d); chk("R10 same-cycle addr", d, 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    wr(12'h400, 32'h0F);
    wr(dat(8'hFF), 32'hF5);
    rd(dat(8'hFF), d); chk("R4 out bits", d[3:0], 32'h5);
    wr(12'h400, 32'hFF);
    rd(dat(8'hF0), d); chk("R2 input bits not stored", d, 0);
    wr(12'h400, 32'h0F);
    @(negedge clk); pin_in = 8'hA3; bus_addr = dat(8'hFF);
    @(negedge clk); #0.5 chk("R4 after one edge", bus_rdata, 32'h05);
    @(negedge clk); #0.5 chk("R4 after two edges", bus_rdata, 32'hA5);
    rd(dat(8'h30), d); chk("R3 input masked", d, 32'h20);
  endtask

  task automatic t_hole();
    logic [31:0] d;
    wr(12'h404, 32'h00);
    wr(12'hFFC, 32'h00);
    wr(12'h800, 32'h00);
    rd(12'h400, d); chk("R9 dir kept", d, 32'h0F);
    rd(dat(8'h0F), d); chk("R9 data kept", d, 32'h05);
    rd(12'h404, d); chk("R9 hole read", d, 0);
    rd(12'hC00, d); chk("R9 high read", d, 0);
  endtask

  initial begin
    rst = 1; bus_addr = 0; bus_wr = 0; bus_wdata = 0; pin_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_dir();
    t_mask_write();
    t_timing();
    t_input();
    t_hole();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule